// File: doc/BRIEF.md
# Execution Unit Clock-Enable Controller

This block decides, cycle by cycle, whether an optional execution unit (a divider, for instance) in a pipelined core gets its register enable. It watches the instruction types at decode and at issue. When nothing needs the unit, it drops the enable so that the unit's pipeline registers hold their contents and the logic between them stops switching. When the enable is high, the unit runs normally. Operations already inside the unit always drain before the enable is dropped.

There are two policies, picked by one input. The timing-transparent policy turns the unit on as soon as a unit-needing instruction is seen at decode, one stage before issue. Gating then never delays any instruction. The aggressive policy ignores decode. It gates after a programmable run of idle cycles. When an instruction needing the unit reaches issue while the unit is off, that instruction is held for a fixed two-cycle wake-up. A 32-bit counter totals the cycles spent with the unit off.

Top module: `exu_gate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, unit_en is 1, iss_stall is 0 and gated_cycles is 0.
- R2: Once an instruction is accepted at issue (valid, needing the unit, not stalled, in cycle t), unit_en stays 1 in cycles t+1 through t+LAT, where LAT is the unit depth (default 3).
- R3: In timing-transparent mode (mode_aggr = 0), a valid unit-needing instruction at decode in cycle t makes unit_en 1 in cycle t+1, so that instruction is not stalled at issue in t+1.
- R4: In timing-transparent mode, with no unit-needing instruction at decode or at issue, unit_en drops in the cycle after the last in-flight operation leaves the unit (cycle t+LAT+1 for an issue in cycle t). The same applies one cycle after reset when the unit is empty.
- R5: In aggressive mode (mode_aggr = 1), unit_en drops after idle_limit consecutive cycles in which the unit holds no operation and none is issued. An issue in cycle t gives gating in cycle t+LAT+idle_limit. After reset, with no activity, gating happens in cycle idle_limit. An idle_limit of 0 behaves as 1.
- R6: In aggressive mode the decode inputs have no effect: a unit-needing instruction at decode does not re-enable a gated unit.
- R7: In aggressive mode, a valid unit-needing instruction at issue while the unit is gated raises iss_stall in that cycle and in the next. unit_en becomes 1 and iss_stall 0 in the third cycle.
- R8: iss_stall is 1 only for an instruction with both iss_valid and iss_needs_unit set. An invalid or non-needing instruction neither stalls nor wakes the unit.
- R9: gated_cycles rises by exactly one for each cycle in which unit_en is 0, and holds while unit_en is 1.
- R10: Once a wake-up has started, it completes and unit_en reaches 1 two cycles after the request, even if the request is withdrawn.
- R11: In aggressive mode, an issue restarts the idle run: a second issue before gating delays gating to LAT+idle_limit cycles after that second issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_aggr | input | 1 | 0 = timing-transparent policy, 1 = aggressive policy |
| idle_limit | input | IDLE_W | Idle cycles before gating in aggressive mode |
| dec_valid | input | 1 | A valid instruction is at decode |
| dec_needs_unit | input | 1 | The decode instruction uses the gated unit |
| iss_valid | input | 1 | A valid instruction is at issue |
| iss_needs_unit | input | 1 | The issue instruction uses the gated unit |
| unit_en | output | 1 | Register enable for the unit's pipeline |
| iss_stall | output | 1 | Holds the issue stage this cycle |
| gated_cycles | output | CNT_W | Running count of cycles with the unit off |

## Verification
The hardest situation to reach is an aggressive-mode wake-up that overlaps other activity. Examples are a request withdrawn during the wake, or a second issue that lands just before the idle run would expire. Both depend on exact cycle alignment against an internal idle run that the ports do not show. The bench sets a small idle_limit and gates the unit deliberately. It then places each issue a counted number of cycles after the wake request or the previous issue. This lets the expected gating cycle be worked out as issue cycle plus unit depth plus limit, and checked on both sides of the edge.

// File: rtl/exu_gate_pkg.sv
package exu_gate_pkg;

    typedef enum logic [1:0] {
        GS_ON    = 2'd0,
        GS_OFF   = 2'd1,
        GS_WAKE  = 2'd2
    } gate_st_e;

endpackage

// File: rtl/exu_gate_inflight.sv
module exu_gate_inflight #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_go,
    output logic busy_now,
    output logic busy_next
);
    logic [LAT-1:0] occ_d, occ_q;

    generate
        if (LAT == 1) begin : g_single
            always_comb occ_d = op_go;
        end else begin : g_shift
            always_comb occ_d = {occ_q[LAT-2:0], op_go};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign busy_now  = |occ_q;
    assign busy_next = |occ_d;
endmodule

// File: rtl/exu_gate_tally.sv
module exu_gate_tally #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + {{(W-1){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/exu_gate_ctrl.sv
module exu_gate_ctrl
    import exu_gate_pkg::*;
#(
    parameter int LAT      = 3,
    parameter int IDLE_W   = 8,
    parameter int WAKE_LAT = 2,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_aggr,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              dec_valid,
    input  logic              dec_needs_unit,
    input  logic              iss_valid,
    input  logic              iss_needs_unit,
    output logic              unit_en,
    output logic              iss_stall,
    output logic [CNT_W-1:0]  gated_cycles
);
    localparam int WK_W = $clog2(WAKE_LAT + 1);

    typedef struct packed {
        gate_st_e          st;
        logic [IDLE_W-1:0] idle;
        logic [WK_W-1:0]   wk;
    } ctl_s;

    ctl_s r_d, r_q;

    logic dec_need, iss_need, iss_go;
    logic busy_now, busy_next;
    logic [IDLE_W:0] idle_inc;

    always_comb begin
        dec_need  = dec_valid & dec_needs_unit;
        iss_need  = iss_valid & iss_needs_unit;
        unit_en   = (r_q.st == GS_ON);
        iss_stall = iss_need & (r_q.st != GS_ON);
        iss_go    = iss_need & (r_q.st == GS_ON);
    end

    exu_gate_inflight #(.LAT(LAT)) u_inflight (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_go     (iss_go),
        .busy_now  (busy_now),
        .busy_next (busy_next)
    );

    exu_gate_tally #(.W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (r_q.st != GS_ON),
        .count (gated_cycles)
    );

    always_comb begin
        r_d      = r_q;
        idle_inc = {1'b0, r_q.idle} + 1'b1;
        case (r_q.st)
            GS_ON: begin
                if (!mode_aggr) begin
                    r_d.idle = '0;
                    if (!(dec_need || iss_need || busy_next)) r_d.st = GS_OFF;
                end else if (busy_next) begin
                    r_d.idle = '0;
                end else if (idle_inc >= {1'b0, idle_limit}) begin
                    r_d.idle = '0;
                    r_d.st   = GS_OFF;
                end else begin
                    r_d.idle = idle_inc[IDLE_W-1:0];
                end
            end
            GS_OFF: begin
                r_d.idle = '0;
                if (!mode_aggr) begin
                    if (dec_need || iss_need) r_d.st = GS_ON;
                end else if (iss_need) begin
                    r_d.st = GS_WAKE;
                    r_d.wk = WK_W'(WAKE_LAT - 1);
                end
            end
            GS_WAKE: begin
                r_d.idle = '0;
                if (r_q.wk <= WK_W'(1)) begin
                    r_d.st = GS_ON;
                    r_d.wk = '0;
                end else begin
                    r_d.wk = r_q.wk - 1'b1;
                end
            end
            default: r_d.st = GS_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= GS_ON;
            r_q.idle <= '0;
            r_q.wk   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: operations inside the unit always see an enabled pipeline
    p_drain_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_now |-> unit_en);

    // R3: decode-time need always enables the unit for the next cycle
    p_early_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_aggr && dec_need && r_q.st != GS_WAKE) |=> unit_en);

    // R7: an aggressive wake request cannot enable the unit at once
    p_wake_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_aggr && r_q.st == GS_OFF && iss_need) |=> !unit_en);

    // R8: an accepted issue always lands in an enabled unit
    p_issue_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_need && !iss_stall) |-> unit_en);

    // R9: counter advances only on gated cycles
    p_tally_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (gated_cycles == $past(gated_cycles) + 1'b1));

    p_tally_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en |=> $stable(gated_cycles));
endmodule

// File: tb/exu_gate_ctrl_tb.sv
module exu_gate_ctrl_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_aggr = 1'b0;
    logic [7:0]  idle_limit = 8'd4;
    logic        dec_valid = 1'b0, dec_needs_unit = 1'b0;
    logic        iss_valid = 1'b0, iss_needs_unit = 1'b0;
    logic        unit_en, iss_stall;
    logic [31:0] gated_cycles;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    exu_gate_ctrl #(.LAT(LAT), .IDLE_W(8), .WAKE_LAT(2), .CNT_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_aggr(mode_aggr), .idle_limit(idle_limit),
        .dec_valid(dec_valid), .dec_needs_unit(dec_needs_unit),
        .iss_valid(iss_valid), .iss_needs_unit(iss_needs_unit),
        .unit_en(unit_en), .iss_stall(iss_stall), .gated_cycles(gated_cycles)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_dec(logic v);
        dec_valid = v; dec_needs_unit = v;
    endtask

    task automatic set_iss(logic v);
        iss_valid = v; iss_needs_unit = v;
    endtask

    task automatic do_reset(logic aggr, logic [7:0] lim);
        rst_n = 1'b0; mode_aggr = aggr; idle_limit = lim;
        set_dec(0); set_iss(0);
        @(negedge clk); @(negedge clk);
        #1;
        chk("R1 en in reset", unit_en, 1);
        chk("R1 cnt in reset", gated_cycles, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 en after release", unit_en, 1);
        chk("R1 stall after release", iss_stall, 0);
        chk("R1 cnt after release", gated_cycles, 0);
    endtask

    task automatic t_transparent();
        do_reset(1'b0, 8'd4);
        tick();
        chk("R4 gate on empty unit", unit_en, 0);
        set_dec(1);
        tick();
        chk("R3 en after decode", unit_en, 1);
        set_dec(0); set_iss(1);
        #1;
        chk("R3 no stall", iss_stall, 0);
        tick();
        set_iss(0);
        chk("R2 en t+1", unit_en, 1);
        tick();
        chk("R2 en t+2", unit_en, 1);
        tick();
        chk("R2 en t+LAT", unit_en, 1);
        tick();
        chk("R4 gate at t+LAT+1", unit_en, 0);
        // back-to-back stream: decode then issue every cycle
        set_dec(1);
        tick();
        for (int i = 0; i < 3; i++) begin
            set_iss(1);
            #1;
            chk("R3 stream no stall", iss_stall, 0);
            tick();
        end
        set_dec(0); set_iss(0);
    endtask

    task automatic t_aggressive();
        logic [31:0] c0;
        do_reset(1'b1, 8'd4);
        tick(); tick(); tick();
        chk("R5 en before limit", unit_en, 1);
        tick();
        chk("R5 gate at limit", unit_en, 0);
        // R6: decode ignored
        set_dec(1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6 decode ignored", unit_en, 0);
        end
        set_dec(0);
        // R8: invalid or non-needing instructions
        iss_valid = 1'b1; iss_needs_unit = 1'b0;
        #1;
        chk("R8 no stall non-needing", iss_stall, 0);
        tick();
        chk("R8 no wake non-needing", unit_en, 0);
        iss_valid = 1'b0; iss_needs_unit = 1'b1;
        #1;
        chk("R8 no stall invalid", iss_stall, 0);
        tick();
        chk("R8 no wake invalid", unit_en, 0);
        iss_needs_unit = 1'b0;
        // R9: counting while gated
        c0 = gated_cycles;
        for (int i = 0; i < 5; i++) tick();
        chk("R9 five gated cycles", gated_cycles - c0, 5);
        // R7: wake with stall
        set_iss(1);
        #1;
        chk("R7 stall first", iss_stall, 1);
        tick();
        chk("R7 stall second", iss_stall, 1);
        chk("R7 en off second", unit_en, 0);
        tick();
        chk("R7 en third", unit_en, 1);
        chk("R7 stall released", iss_stall, 0);
        c0 = gated_cycles;
        tick();
        set_iss(0);
        for (int i = 0; i < 5; i++) tick();
        chk("R5 en at t+6", unit_en, 1);
        chk("R9 hold while enabled", gated_cycles, c0);
        tick();
        chk("R5 gate at t+LAT+limit", unit_en, 0);
        // R10: withdrawn request still completes
        set_iss(1);
        tick();
        set_iss(0);
        chk("R10 still off", unit_en, 0);
        tick();
        chk("R10 wake completes", unit_en, 1);
        // limit 0 behaves as 1
        idle_limit = 8'd0;
        tick();
        chk("R5 limit zero", unit_en, 0);
        idle_limit = 8'd4;
        // R11: second issue restarts idle run
        set_iss(1);
        tick(); tick();
        chk("R11 woken", unit_en, 1);
        tick();
        set_iss(0);
        tick(); tick(); tick();
        set_iss(1);
        #1;
        chk("R11 second issue no stall", iss_stall, 0);
        tick();
        set_iss(0);
        for (int i = 0; i < 5; i++) tick();
        chk("R11 en at t2+6", unit_en, 1);
        tick();
        chk("R11 gate at t2+7", unit_en, 0);
    endtask

    initial begin
        t_transparent();
        t_aggressive();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule